// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This block resolves a family of three compare-against-zero conditional branches for a 32-bit core with one branch delay slot. Each cycle it sees the presented instruction word, the address of that word, the value of its source register and a valid strobe. It decodes the word and evaluates the branch condition in the same cycle. It computes the target and raises an illegal-encoding flag when the reserved field is not zero.

A three-state sequencer records an accepted branch and waits for the next valid instruction, which is the delay-slot instruction. While that instruction is presented, the block can cancel it (the likely form, when not taken) or flag it (when it is itself a branch). In the cycle after the slot instruction is accepted, the block issues a single-cycle redirect to the fetch side. The variants are greater-than-zero, its likely form, and less-than-or-equal-to-zero.

Top module: `dbr_unit`

## Requirements
- R1: Opcode bits 31:26 equal to 6'b000111 (greater-than-zero), 6'b010111 (greater-than-zero, likely) or 6'b000110 (less-or-equal-zero), with bits 20:16 zero and the valid strobe high, assert `branch_o` in the same cycle regardless of sequencer state; any other opcode leaves `branch_o`, `taken_o` and `illegal_o` low.
- R2: One of those opcodes with nonzero bits 20:16 asserts `illegal_o`, keeps `branch_o` and `taken_o` low, and never starts a sequence or a redirect.
- R3: For both greater-than-zero opcodes, `taken_o` is high only when bit 31 of the operand is 0 and the operand is not zero.
- R4: For the less-or-equal-zero opcode, `taken_o` is high when bit 31 of the operand is 1 or the operand is zero.
- R5: `target_o` equals the branch address plus 4 plus the sign-extended bits 15:0 shifted left by 2, wrapping modulo 2^32, which gives a range from -131072 to +131068 bytes around the slot address.
- R6: After a taken legal branch is accepted while idle, `redirect_valid_o` is high for exactly one cycle. That cycle follows the cycle in which the next valid instruction is accepted, and `redirect_pc_o` then carries the target. No other event produces a redirect.
- R7: Cycles with the valid strobe low between a branch and its slot instruction are not counted as the slot: no redirect, nullify or hazard is produced until a valid instruction arrives.
- R8: `slot_nullify_o` is high while the slot instruction is presented only when the branch was the likely form and not taken; it stays low for the other two opcodes and for a taken likely branch.
- R9: A family branch presented as the slot instruction asserts `slot_hazard_o` in that cycle and does not start a new sequence; the pending redirect of the first branch is still issued.
- R10: An instruction presented in the redirect cycle is discarded by the sequencer and starts no sequence.
- R11: Active-low asynchronous reset returns the sequencer to idle and clears any pending redirect and nullify.
- R12: `src_idx_o` carries instruction bits 25:21 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction word |
| rs_val_i | input | 32 | Value of the source register |
| src_idx_o | output | 5 | Source register index field |
| branch_o | output | 1 | Legal branch of the family presented |
| illegal_o | output | 1 | Family opcode with nonzero reserved field |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 32 | Computed branch target |
| slot_nullify_o | output | 1 | Cancel the presented delay-slot instruction |
| slot_hazard_o | output | 1 | Delay-slot instruction is itself a branch |
| redirect_valid_o | output | 1 | One-cycle redirect request |
| redirect_pc_o | output | 32 | Redirect address |

## Verification
The bench probes the sign and zero edges of the operand: zero, 0x80000000 and all ones. A design that tests only the sign bit would take a greater-than-zero branch on zero or miss a less-or-equal branch on zero. It uses the offset extremes 0x7FFF and 0x8000, a target that wraps past 2^32, and stalled cycles between a branch and its slot; a wrong extension or a design that counts an invalid cycle as the slot would redirect to the wrong place or redirect too early. It also puts a branch in the delay slot, presents a branch in the redirect cycle, and applies reset while a slot is pending; a sequencer that restarts on any of these would produce an extra redirect, which the scoreboard reports as unexpected.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned REG_W = 5;
  localparam int unsigned IMM_W = 16;

  localparam logic [OP_W-1:0] OPC_GTZ  = 6'b000111;
  localparam logic [OP_W-1:0] OPC_GTZL = 6'b010111;
  localparam logic [OP_W-1:0] OPC_LEZ  = 6'b000110;

  typedef enum logic [1:0] {BK_NONE, BK_GTZ, BK_GTZL, BK_LEZ} br_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_REDIR} seq_state_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [IMM_W-1:0] imm;
  } br_word_t;
endpackage

// File: rtl/dbr_decode.sv
`timescale 1ns/1ps
module dbr_decode
  import dbr_pkg::*;
(
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rt_i,
  output logic             fam_o,
  output logic             legal_o,
  output logic             illegal_o,
  output logic             likely_o,
  output logic             lez_o
);
  br_kind_e kind;

  always_comb begin
    unique case (op_i)
      OPC_GTZ:  kind = BK_GTZ;
      OPC_GTZL: kind = BK_GTZL;
      OPC_LEZ:  kind = BK_LEZ;
      default:  kind = BK_NONE;
    endcase
  end

  logic rt_zero;
  assign rt_zero   = (rt_i == '0);
  assign fam_o     = valid_i && (kind != BK_NONE);
  assign legal_o   = fam_o && rt_zero;
  assign illegal_o = fam_o && !rt_zero;
  assign likely_o  = (kind == BK_GTZL);
  assign lez_o     = (kind == BK_LEZ);
endmodule

// File: rtl/dbr_cond.sv
`timescale 1ns/1ps
module dbr_cond #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            lez_i,
  output logic            cond_o
);
  logic neg, zero;
  assign neg  = val_i[XLEN-1];
  assign zero = (val_i == '0);
  // lez and gtz are exact complements
  assign cond_o = lez_i ? (neg || zero) : !(neg || zero);
endmodule

// File: rtl/dbr_target.sv
`timescale 1ns/1ps
module dbr_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned SCALED_W = OFF_W + SHIFT;
  localparam int unsigned INSN_B   = 4;

  logic [SCALED_W-1:0] scaled;
  logic [XLEN-1:0]     disp;
  logic [XLEN-1:0]     slot_pc;

  assign scaled  = {off_i, {SHIFT{1'b0}}};
  assign slot_pc = pc_i + XLEN'(INSN_B);

  generate
    if (XLEN > SCALED_W) begin : g_ext
      assign disp = {{(XLEN-SCALED_W){scaled[SCALED_W-1]}}, scaled};
    end else begin : g_trunc
      assign disp = scaled[XLEN-1:0];
    end
  endgenerate

  // wraps modulo 2^XLEN, no overflow flag
  assign target_o = slot_pc + disp;
endmodule

// File: rtl/dbr_seq.sv
`timescale 1ns/1ps
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            start_i,
  input  logic            taken_i,
  input  logic            likely_i,
  input  logic            slot_fam_i,
  input  logic [XLEN-1:0] target_i,
  output logic            slot_nullify_o,
  output logic            slot_hazard_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  seq_state_e      state_q, state_d;
  logic            taken_q, likely_q;
  logic [XLEN-1:0] target_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SLOT;
      ST_SLOT:  if (valid_i) state_d = taken_q ? ST_REDIR : ST_IDLE;
      ST_REDIR: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      taken_q  <= 1'b0;
      likely_q <= 1'b0;
      target_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        taken_q  <= taken_i;
        likely_q <= likely_i;
        target_q <= target_i;
      end
    end
  end

  logic in_slot;
  assign in_slot          = (state_q == ST_SLOT) && valid_i;
  assign slot_nullify_o   = in_slot && likely_q && !taken_q;
  assign slot_hazard_o    = in_slot && slot_fam_i;
  assign redirect_valid_o = (state_q == ST_REDIR);
  assign redirect_pc_o    = redirect_valid_o ? target_q : '0;

  // R6
  redir_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o);
  // R6
  redir_after_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(redirect_valid_o) |-> $past(in_slot));
  // R8
  nullify_no_redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_nullify_o |=> !redirect_valid_o);
  // R9
  hazard_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_hazard_o |=> state_q != ST_SLOT);
endmodule

// File: rtl/dbr_unit.sv
`timescale 1ns/1ps
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_val_i,
  output logic [REG_W-1:0] src_idx_o,
  output logic             branch_o,
  output logic             illegal_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  target_o,
  output logic             slot_nullify_o,
  output logic             slot_hazard_o,
  output logic             redirect_valid_o,
  output logic [XLEN-1:0]  redirect_pc_o
);
  br_word_t word;
  logic     fam, legal, likely, lez, cond;

  assign word      = br_word_t'(instr_i);
  assign src_idx_o = word.rs;

  dbr_decode u_dec (
    .valid_i   (instr_valid_i),
    .op_i      (word.op),
    .rt_i      (word.rt),
    .fam_o     (fam),
    .legal_o   (legal),
    .illegal_o (illegal_o),
    .likely_o  (likely),
    .lez_o     (lez)
  );

  dbr_cond #(.XLEN(XLEN)) u_cond (
    .val_i  (rs_val_i),
    .lez_i  (lez),
    .cond_o (cond)
  );

  dbr_target #(.XLEN(XLEN), .OFF_W(IMM_W), .SHIFT(SHIFT)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (word.imm),
    .target_o (target_o)
  );

  assign branch_o = legal;
  assign taken_o  = legal && cond;

  dbr_seq #(.XLEN(XLEN)) u_seq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .valid_i          (instr_valid_i),
    .start_i          (legal),
    .taken_i          (taken_o),
    .likely_i         (likely),
    .slot_fam_i       (fam),
    .target_i         (target_o),
    .slot_nullify_o   (slot_nullify_o),
    .slot_hazard_o    (slot_hazard_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
  );

  // R2
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !branch_o && !taken_o);
  // R3
  gtz_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_o && !lez && rs_val_i == '0) |-> !taken_o);
  // R4
  lez_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_o && lez && rs_val_i == '0) |-> taken_o);
endmodule

// File: tb/dbr_unit_tb_top.sv
`timescale 1ns/1ps
module dbr_unit_tb_top;
  localparam logic [5:0] GTZ  = 6'b000111;
  localparam logic [5:0] GTZL = 6'b010111;
  localparam logic [5:0] LEZ  = 6'b000110;
  localparam logic [31:0] NOP = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] ins = '0, pc = '0, rsv = '0;
  logic [4:0]  src_idx;
  logic        br, ill, tk, nul, haz, rdv;
  logic [31:0] tgt, rdpc;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  dbr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(vld), .instr_i(ins),
    .pc_i(pc), .rs_val_i(rsv), .src_idx_o(src_idx), .branch_o(br),
    .illegal_o(ill), .taken_o(tk), .target_o(tgt), .slot_nullify_o(nul),
    .slot_hazard_o(haz), .redirect_valid_o(rdv), .redirect_pc_o(rdpc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic is_fam(input logic [5:0] op);
    return op == GTZ || op == GTZL || op == LEZ;
  endfunction

  function automatic logic cond_of(input logic [5:0] op, input logic [31:0] v);
    if (op == LEZ) return v[31] || v == 0;
    return !v[31] && v != 0;
  endfunction

  function automatic logic [31:0] tgt_of(input logic [31:0] p, input logic [15:0] off);
    return p + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] off);
    return {op, rs, rt, off};
  endfunction

  // drive one cycle and check the same-cycle outputs
  task automatic step(input logic v, input logic [31:0] i, input logic [31:0] p,
                      input logic [31:0] r, input logic e_nul, input logic e_haz, input string req);
    logic e_fam, e_br;
    @(negedge clk);
    vld = v; ins = i; pc = p; rsv = r;
    #1;
    e_fam = v && is_fam(i[31:26]);
    e_br  = e_fam && i[20:16] == 0;
    chk(req, "branch_o", br, e_br);
    chk(req, "illegal_o", ill, e_fam && i[20:16] != 0);
    chk(req, "taken_o", tk, e_br && cond_of(i[31:26], r));
    if (e_br) chk(req, "target_o", tgt, tgt_of(p, i[15:0]));
    chk(req, "slot_nullify_o", nul, e_nul);
    chk(req, "slot_hazard_o", haz, e_haz);
  endtask

  // branch, its slot, then two idle cycles
  task automatic pair(input logic [5:0] op, input logic [4:0] rt, input logic [31:0] r,
                      input logic [31:0] p, input logic [15:0] off, input logic [31:0] slot,
                      input string req);
    logic e_br, e_tk;
    e_br = is_fam(op) && rt == 0;
    e_tk = e_br && cond_of(op, r);
    step(1'b1, mk(op, 5'd3, rt, off), p, r, 1'b0, 1'b0, req);
    if (e_br && e_tk) exp_q.push_back(tgt_of(p, off));
    step(1'b1, slot, p + 4, 32'd0, e_br && op == GTZL && !e_tk,
         e_br && is_fam(slot[31:26]), req);
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, req);
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, req);
  endtask

  // scoreboard monitor for redirects (R6)
  always @(negedge clk) begin
    if (rst_n && !done && rdv) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected redirect actual=%h expected=none", rdpc);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (rdpc !== e) begin
          fails++;
          $display("FAIL R6 redirect_pc_o actual=%h expected=%h", rdpc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "redirect_valid_o", rdv, 1'b0);
    chk("R11", "slot_nullify_o", nul, 1'b0);

    // R12 source index field
    step(1'b1, mk(6'h00, 5'd17, 5'd0, 16'h0), 32'h100, '0, 1'b0, 1'b0, "R1");
    chk("R12", "src_idx_o", src_idx, 5'd17);

    // R3 gtz taken, positive offset
    pair(GTZ, 5'd0, 32'd5, 32'h0000_1000, 16'h0010, NOP, "R3");
    // R3 zero and most-negative not taken
    pair(GTZ, 5'd0, 32'd0, 32'h0000_1100, 16'h0010, NOP, "R3");
    pair(GTZ, 5'd0, 32'h8000_0000, 32'h0000_1200, 16'h0010, NOP, "R3");
    pair(GTZ, 5'd0, 32'h7FFF_FFFF, 32'h0000_1300, 16'hFFF0, NOP, "R3");
    // R4 lez: zero, all ones, positive
    pair(LEZ, 5'd0, 32'd0, 32'h0000_2000, 16'hFFFF, NOP, "R4");
    pair(LEZ, 5'd0, 32'hFFFF_FFFF, 32'h0000_2100, 16'h0004, NOP, "R4");
    pair(LEZ, 5'd0, 32'd1, 32'h0000_2200, 16'h0004, NOP, "R4");
    // R8 likely: taken -> no nullify; not taken -> nullify
    pair(GTZL, 5'd0, 32'd7, 32'h0000_3000, 16'h0020, NOP, "R8");
    pair(GTZL, 5'd0, 32'd0, 32'h0000_3100, 16'h0020, NOP, "R8");
    pair(GTZL, 5'd0, 32'h8000_0001, 32'h0000_3200, 16'h0020, NOP, "R8");
    // R5 wrap and range extremes
    pair(GTZ, 5'd0, 32'd1, 32'hFFFF_FFF0, 16'h0010, NOP, "R5");
    pair(LEZ, 5'd0, 32'd0, 32'h0010_0000, 16'h7FFF, NOP, "R5");
    pair(LEZ, 5'd0, 32'd0, 32'h0010_0000, 16'h8000, NOP, "R5");
    // R2 illegal encoding: no sequence, no nullify on the next word
    pair(GTZL, 5'd1, 32'd0, 32'h0000_4000, 16'h0010, NOP, "R2");
    pair(GTZ, 5'd9, 32'd3, 32'h0000_4100, 16'h0010, NOP, "R2");
    // R1 non-family opcode
    pair(6'b000100, 5'd0, 32'd3, 32'h0000_4200, 16'h0010, NOP, "R1");

    // R7 stalled cycles before the slot
    step(1'b1, mk(GTZ, 5'd2, 5'd0, 16'h0008), 32'h0000_5000, 32'd9, 1'b0, 1'b0, "R7");
    exp_q.push_back(tgt_of(32'h0000_5000, 16'h0008));
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R7");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R7");
    chk("R7", "redirect before slot", rdv, 1'b0);
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R7");
    step(1'b1, NOP, 32'h0000_5004, '0, 1'b0, 1'b0, "R7");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R7");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R7");

    // R9 branch in the delay slot: flagged, not restarted
    pair(GTZ, 5'd0, 32'd4, 32'h0000_6000, 16'h0040, mk(GTZ, 5'd1, 5'd0, 16'h0100), "R9");
    pair(GTZL, 5'd0, 32'd0, 32'h0000_6100, 16'h0040, mk(LEZ, 5'd1, 5'd0, 16'h0100), "R9");
    step(1'b1, NOP, 32'h0000_6200, '0, 1'b0, 1'b0, "R9");

    // R10 branch presented in the redirect cycle is discarded
    step(1'b1, mk(GTZ, 5'd2, 5'd0, 16'h0002), 32'h0000_7000, 32'd1, 1'b0, 1'b0, "R10");
    exp_q.push_back(tgt_of(32'h0000_7000, 16'h0002));
    step(1'b1, NOP, 32'h0000_7004, '0, 1'b0, 1'b0, "R10");
    step(1'b1, mk(GTZL, 5'd2, 5'd0, 16'h0002), 32'h0000_9000, 32'd0, 1'b0, 1'b0, "R10");
    step(1'b1, NOP, 32'h0000_9004, '0, 1'b0, 1'b0, "R10");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R10");

    // R11 reset while a slot is pending
    step(1'b1, mk(GTZL, 5'd2, 5'd0, 16'h0010), 32'h0000_8000, 32'd0, 1'b0, 1'b0, "R11");
    @(negedge clk);
    vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, NOP, 32'h0000_8004, '0, 1'b0, 1'b0, "R11");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R11");
    step(1'b0, NOP, '0, '0, 1'b0, 1'b0, "R11");

    chk("R6", "pending redirects", exp_q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule